// File: doc/BRIEF.md
# Block-Aligned DMA Request Splitter

This block takes one DMA command at a time (direction, start address, byte length, data-buffer base offset and a transfer tag) and cuts it into memory requests that never straddle a block boundary. The block size is a power of two set by a parameter. The first piece runs from the start address up to the next boundary, or to the end of the transfer if that comes first. The pieces in the middle are full blocks. The last piece carries whatever remains.

The pieces are written into a transmit queue, one per cycle. Each piece enqueued raises a one-cycle strobe, so an outstanding-request tracker can count it. The head of the queue is offered on a request port, with at most one attempt per cycle. If the port refuses the head, the block stops offering and keeps that entry until a retry pulse arrives. It then offers the same entry again.

A command is admitted only when every piece it produces fits in the free queue space. A command of zero length is taken off the command port and flagged as an error, and so is a command needing more pieces than the queue can ever hold. Neither of these enqueues anything.

Top module: `dma_chunk_splitter`

## Requirements
- R1: The first request of a command covers the bytes from the start address to the next block boundary (an address whose low log2(BLK_BYTES) bits are zero), or the whole length if the end comes first. No request ever crosses a boundary.
- R2: After the first request, every request is a full block except the last, which holds the remainder. The sizes sum to the command length, the addresses ascend contiguously, and no request has size zero.
- R3: Each request's req_ofs_o equals the command's base offset plus the bytes covered by the earlier requests of the same command.
- R4: Every request of a command carries that command's req_id_o and req_write_o values.
- R5: When the port accepts a request (req_valid_o and req_ready_i both high at a rising edge), that entry leaves the queue. If the port stays ready, the next request of the same command is offered in the very next cycle.
- R6: When req_valid_o is high and req_ready_i is low at an edge, req_valid_o is low from the next cycle on until a retry_i pulse. In the cycle after the pulse, the same request is offered again with identical fields.
- R7: A command with length zero, or one needing more than Q_DEPTH requests, is accepted with cmd_err_o high in the accepting cycle and produces no queue strobe and no request.
- R8: cmd_ready_o is low while the previous command is still being enqueued, and low while the free queue space is smaller than the number of requests the offered command needs.
- R9: q_push_o pulses exactly once for each request enqueued, with q_push_id_o carrying the command's tag.
- R10: After reset, req_valid_o and q_push_o are low. req_valid_o is never high while the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command taken at this edge |
| cmd_write_i | input | 1 | Direction: 1 write, 0 read |
| cmd_addr_i | input | ADDR_W | Start byte address |
| cmd_len_i | input | LEN_W | Length in bytes |
| cmd_base_i | input | OFS_W | Data buffer base offset |
| cmd_id_i | input | ID_W | Transfer tag |
| cmd_err_o | output | 1 | Offered command is zero-length or too large |
| q_push_o | output | 1 | One pulse per request enqueued |
| q_push_id_o | output | ID_W | Tag of the enqueued request |
| req_valid_o | output | 1 | Request attempt this cycle |
| req_ready_i | input | 1 | Port accepts the request |
| retry_i | input | 1 | Port invites a new attempt after a refusal |
| req_write_o | output | 1 | Request direction |
| req_addr_o | output | ADDR_W | Request address |
| req_size_o | output | log2(BLK_BYTES)+1 | Request size in bytes |
| req_ofs_o | output | OFS_W | Offset into the data buffer |
| req_id_o | output | ID_W | Transfer tag |

## Verification
The properties take for granted that the command fields stay constant while cmd_valid_i is high and not yet accepted. They also take for granted that retry_i matters only after a refusal, and that the port judges an attempt only while req_valid_o is high. The stimulus keeps within these limits. It holds each command until cmd_ready_o is seen. It raises retry_i only after it has observed a refused attempt and then seen req_valid_o stay low. It changes req_ready_i only on falling edges. Against a 16-byte block, the sweep covers every start offset inside a block, with lengths from one byte to well past two blocks. Both the always-ready port and the refuse-once port are exercised. Full-queue admission and oversize rejection are also covered.

// File: rtl/dma_split_pkg.sv
package dma_split_pkg;
  typedef enum logic [0:0] {ISS_RUN = 1'b0, ISS_WAIT = 1'b1} iss_state_e;
endpackage

// File: rtl/chunk_fifo.sv
module chunk_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  input  logic             pop_i,
  output logic [W-1:0]     dout_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] count_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= wptr_q + 1'b1;
      if (pop_i)  rptr_q <= rptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout_o  = mem_q[rptr_q];
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;
endmodule

// File: rtl/chunk_gen.sv
module chunk_gen #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 12,
  parameter int OFS_W     = 16,
  parameter int ID_W      = 4,
  parameter int BLK_BYTES = 64,
  parameter int Q_DEPTH   = 16,
  localparam int BLK_LG   = $clog2(BLK_BYTES),
  localparam int SZ_W     = BLK_LG + 1,
  localparam int CNT_W    = $clog2(Q_DEPTH + 1),
  localparam int SPAN_W   = LEN_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_write_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  input  logic [OFS_W-1:0]  cmd_base_i,
  input  logic [ID_W-1:0]   cmd_id_i,
  input  logic [CNT_W-1:0]  q_count_i,
  output logic              cmd_ready_o,
  output logic              cmd_err_o,
  output logic              push_o,
  output logic              push_write_o,
  output logic [ADDR_W-1:0] push_addr_o,
  output logic [SZ_W-1:0]   push_size_o,
  output logic [OFS_W-1:0]  push_ofs_o,
  output logic [ID_W-1:0]   push_id_o
);
  logic              busy_q, wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [ID_W-1:0]   id_q;

  // pieces needed: ceil((start offset in block + len) / block)
  logic [SPAN_W-1:0] span, n_chunks, free_sp;
  logic              is_zero, too_big, fits, take;
  assign span     = SPAN_W'(cmd_addr_i[BLK_LG-1:0]) + SPAN_W'(cmd_len_i)
                  + SPAN_W'(BLK_BYTES - 1);
  assign n_chunks = span >> BLK_LG;
  assign free_sp  = SPAN_W'(Q_DEPTH) - SPAN_W'(q_count_i);
  assign is_zero  = (cmd_len_i == '0);
  assign too_big  = n_chunks > SPAN_W'(Q_DEPTH);
  assign fits     = n_chunks <= free_sp;

  assign cmd_ready_o = !busy_q && (is_zero || too_big || fits);
  assign cmd_err_o   = cmd_valid_i && !busy_q && (is_zero || too_big);
  assign take        = cmd_valid_i && cmd_ready_o && !is_zero && !too_big;

  logic [SZ_W-1:0] room, sz;
  logic            last;
  assign room = SZ_W'(BLK_BYTES) - SZ_W'(addr_q[BLK_LG-1:0]);
  assign sz   = (LEN_W'(room) > rem_q) ? rem_q[SZ_W-1:0] : room;
  assign last = (LEN_W'(sz) == rem_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      rem_q  <= '0;
      ofs_q  <= '0;
      id_q   <= '0;
    end else if (take) begin
      busy_q <= 1'b1;
      wr_q   <= cmd_write_i;
      addr_q <= cmd_addr_i;
      rem_q  <= cmd_len_i;
      ofs_q  <= cmd_base_i;
      id_q   <= cmd_id_i;
    end else if (busy_q) begin
      addr_q <= addr_q + ADDR_W'(sz);
      rem_q  <= rem_q - LEN_W'(sz);
      ofs_q  <= ofs_q + OFS_W'(sz);
      if (last) busy_q <= 1'b0;
    end
  end

  assign push_o       = busy_q;
  assign push_write_o = wr_q;
  assign push_addr_o  = addr_q;
  assign push_size_o  = sz;
  assign push_ofs_o   = ofs_q;
  assign push_id_o    = id_q;
endmodule

// File: rtl/issue_ctrl.sv
module issue_ctrl
  import dma_split_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic empty_i,
  input  logic req_ready_i,
  input  logic retry_i,
  output logic req_valid_o,
  output logic pop_o
);
  iss_state_e st_q;

  assign req_valid_o = !empty_i && (st_q == ISS_RUN);
  assign pop_o       = req_valid_o && req_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ISS_RUN;
    else begin
      case (st_q)
        ISS_RUN:  if (req_valid_o && !req_ready_i) st_q <= ISS_WAIT;
        ISS_WAIT: if (retry_i) st_q <= ISS_RUN;
        default:  st_q <= ISS_RUN;
      endcase
    end
  end
endmodule

// File: rtl/dma_chunk_splitter.sv
module dma_chunk_splitter #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 12,
  parameter int OFS_W     = 16,
  parameter int ID_W      = 4,
  parameter int BLK_BYTES = 64,
  parameter int Q_DEPTH   = 16,
  localparam int SZ_W     = $clog2(BLK_BYTES) + 1,
  localparam int CNT_W    = $clog2(Q_DEPTH + 1),
  localparam int ENT_W    = 1 + ID_W + ADDR_W + SZ_W + OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_write_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  input  logic [OFS_W-1:0]  cmd_base_i,
  input  logic [ID_W-1:0]   cmd_id_i,
  output logic              cmd_err_o,
  output logic              q_push_o,
  output logic [ID_W-1:0]   q_push_id_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  input  logic              retry_i,
  output logic              req_write_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [SZ_W-1:0]   req_size_o,
  output logic [OFS_W-1:0]  req_ofs_o,
  output logic [ID_W-1:0]   req_id_o
);
  logic              push, pop, empty, g_wr;
  logic [CNT_W-1:0]  count;
  logic [ADDR_W-1:0] g_addr;
  logic [SZ_W-1:0]   g_sz;
  logic [OFS_W-1:0]  g_ofs;
  logic [ID_W-1:0]   g_id;
  logic [ENT_W-1:0]  ent_in, ent_out;

  chunk_gen #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .OFS_W(OFS_W), .ID_W(ID_W),
    .BLK_BYTES(BLK_BYTES), .Q_DEPTH(Q_DEPTH)
  ) u_gen (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_write_i, .cmd_addr_i, .cmd_len_i,
    .cmd_base_i, .cmd_id_i, .q_count_i(count), .cmd_ready_o, .cmd_err_o,
    .push_o(push), .push_write_o(g_wr), .push_addr_o(g_addr),
    .push_size_o(g_sz), .push_ofs_o(g_ofs), .push_id_o(g_id)
  );

  assign ent_in = {g_wr, g_id, g_addr, g_sz, g_ofs};

  chunk_fifo #(.W(ENT_W), .DEPTH(Q_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .din_i(ent_in), .pop_i(pop),
    .dout_o(ent_out), .empty_o(empty), .count_o(count)
  );

  issue_ctrl u_iss (
    .clk_i, .rst_ni, .empty_i(empty), .req_ready_i, .retry_i,
    .req_valid_o, .pop_o(pop)
  );

  assign {req_write_o, req_id_o, req_addr_o, req_size_o, req_ofs_o} = ent_out;
  assign q_push_o    = push;
  assign q_push_id_o = g_id;
endmodule

// File: rtl/dma_chunk_splitter_chk.sv
module dma_chunk_splitter_chk #(
  parameter int ADDR_W    = 32,
  parameter int OFS_W     = 16,
  parameter int BLK_BYTES = 64,
  localparam int BLK_LG   = $clog2(BLK_BYTES),
  localparam int SZ_W     = BLK_LG + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              cmd_ready_o,
  input logic              cmd_err_o,
  input logic              q_push_o,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [SZ_W-1:0]   req_size_o,
  input logic [OFS_W-1:0]  req_ofs_o
);
  logic [SZ_W:0] end_pos;
  assign end_pos = (SZ_W+1)'(req_addr_o[BLK_LG-1:0]) + (SZ_W+1)'(req_size_o);

  // R1
  no_cross_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> end_pos <= (SZ_W+1)'(BLK_BYTES));

  // R2
  nonzero_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> req_size_o != '0);

  // R6
  hold_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> !req_valid_o);

  // R6
  head_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=>
      ($stable(req_addr_o) && $stable(req_size_o) && $stable(req_ofs_o)));

  // R7
  err_no_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o && cmd_err_o) |=> !q_push_o);

  // R8
  busy_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_push_o |-> !cmd_ready_o);
endmodule

bind dma_chunk_splitter dma_chunk_splitter_chk #(
  .ADDR_W(ADDR_W), .OFS_W(OFS_W), .BLK_BYTES(BLK_BYTES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i),
  .cmd_ready_o(cmd_ready_o), .cmd_err_o(cmd_err_o), .q_push_o(q_push_o),
  .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
  .req_addr_o(req_addr_o), .req_size_o(req_size_o), .req_ofs_o(req_ofs_o)
);

// File: tb/dma_chunk_splitter_tb.sv
module dma_chunk_splitter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BLK = 16;
  localparam int QD  = 16;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0, cmd_write_i = 1'b0;
  logic [31:0] cmd_addr_i = '0;
  logic [11:0] cmd_len_i = '0;
  logic [15:0] cmd_base_i = '0;
  logic [3:0]  cmd_id_i = '0;
  logic        req_ready_i = 1'b0, retry_i = 1'b0;
  logic        cmd_ready_o, cmd_err_o, q_push_o, req_valid_o, req_write_o;
  logic [3:0]  q_push_id_o, req_id_o;
  logic [31:0] req_addr_o;
  logic [4:0]  req_size_o;
  logic [15:0] req_ofs_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dma_chunk_splitter #(.BLK_BYTES(BLK), .Q_DEPTH(QD)) u_dut (.*);

  int n_chk = 0, n_fail = 0;
  int push_cnt = 0, push_bad = 0;
  logic [3:0] exp_id = '0;

  always @(negedge clk_i) begin
    if (rst_ni && q_push_o) begin
      push_cnt++;
      if (q_push_id_o != exp_id) push_bad++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put_cmd(input logic [31:0] a, input int len, input logic [15:0] b,
                         input logic [3:0] id, input bit wr);
    cmd_addr_i  = a;
    cmd_len_i   = 12'(len);
    cmd_base_i  = b;
    cmd_id_i    = id;
    cmd_write_i = wr;
    cmd_valid_i = 1'b1;
  endtask

  // called at a negedge; returns at a negedge
  task automatic run_cmd(input logic [31:0] a, input int len, input logic [15:0] b,
                         input logic [3:0] id, input bit wr, input bit rej);
    int n, k, p0, seen, t;
    logic [31:0] ea;
    int erem, esz;
    logic [15:0] eo;
    bit rejected, exp_err, err;
    n = ((a % BLK) + len + BLK - 1) / BLK;
    exp_err = (len == 0) || (n > QD);
    exp_id = id;
    put_cmd(a, len, b, id, wr);
    #1;
    t = 0;
    while (!cmd_ready_o && t < 100) begin @(negedge clk_i); #1; t++; end
    err = cmd_err_o;
    p0 = push_cnt;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    chk(err == exp_err, "R7 err flag", err, exp_err);
    if (exp_err) begin
      repeat (3) @(negedge clk_i);
      #1;
      chk(push_cnt == p0 && !req_valid_o, "R7 nothing enqueued", push_cnt - p0, 0);
      return;
    end
    ea = a; erem = len; eo = b; k = 0; seen = 0; rejected = 0; t = 0;
    while (k < n && t < 400) begin
      t++;
      req_ready_i = !(rej && !rejected);
      #1;
      if (req_valid_o) begin
        esz = (erem < BLK - int'(ea % BLK)) ? erem : BLK - int'(ea % BLK);
        if (seen > 0 || k == 0) seen++;
        chk(req_addr_o == ea, k == 0 ? "R1 first addr" : "R2 addr", req_addr_o, ea);
        chk(int'(req_size_o) == esz, k == 0 ? "R1 first size" : "R2 size", req_size_o, esz);
        chk(req_ofs_o == eo, "R3 data offset", req_ofs_o, eo);
        chk(req_id_o == id && req_write_o == wr, "R4 tag/dir", {req_id_o, req_write_o}, {id, wr});
        if (req_ready_i) begin
          ea += 32'(esz); erem -= esz; eo += 16'(esz); k++; rejected = 0;
          @(negedge clk_i);
        end else begin
          rejected = 1;
          @(negedge clk_i); req_ready_i = 1'b0; #1;
          chk(!req_valid_o, "R6 silent after refusal", req_valid_o, 0);
          @(negedge clk_i); #1;
          chk(!req_valid_o, "R6 silent until retry", req_valid_o, 0);
          retry_i = 1'b1;
          @(negedge clk_i);
          retry_i = 1'b0;
        end
      end else begin
        chk(seen == 0, "R5 back-to-back issue", seen, 0);
        @(negedge clk_i);
      end
    end
    req_ready_i = 1'b0;
    chk(k == n, "R2 request count", k, n);
    if (!rej) chk(seen == n, "R5 one per cycle", seen, n);
    chk(push_cnt - p0 == n, "R9 strobe count", push_cnt - p0, n);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    chk(!req_valid_o && !q_push_o, "R10 reset state", {req_valid_o, q_push_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // sweep: every start offset in a block, lengths 1..40
    for (int off = 0; off < BLK; off++) begin
      for (int len = 1; len <= 40; len++) begin
        run_cmd((32'h4000_0100 + 32'(len << 6)) | 32'(off), len, 16'(len * 3 + off),
                4'((off + len) % 16), len[0], ((off + len) % 5) == 0);
      end
    end

    // R7 corner cases
    run_cmd(32'h2000_0000, 0, 16'h10, 4'h3, 1'b0, 1'b0);
    run_cmd(32'h2000_0001, 256, 16'h10, 4'h4, 1'b0, 1'b0);

    // R8: fill the queue with a 16-request command while the port refuses
    exp_id = 4'h9;
    put_cmd(32'h3000_0000, 256, 16'h0, 4'h9, 1'b1);
    #1;
    chk(cmd_ready_o, "R8 full-fit admitted", cmd_ready_o, 1);
    @(negedge clk_i);
    put_cmd(32'h3000_1000, 1, 16'h0, 4'h1, 1'b0);
    #1;
    chk(!cmd_ready_o, "R8 refused while enqueuing", cmd_ready_o, 0);
    repeat (20) @(negedge clk_i);
    #1;
    chk(!cmd_ready_o, "R8 refused when full", cmd_ready_o, 0);
    chk(push_bad == 0, "R9 strobe tag", push_bad, 0);
    cmd_valid_i = 1'b0;
    retry_i = 1'b1;
    @(negedge clk_i);
    retry_i = 1'b0;
    req_ready_i = 1'b1;
    begin
      int got = 0;
      logic [31:0] last_a = '0;
      for (int i = 0; i < 40; i++) begin
        #1;
        if (req_valid_o) begin got++; last_a = req_addr_o; end
        @(negedge clk_i);
      end
      chk(got == 16, "R5 drain count", got, 16);
      chk(last_a == 32'h3000_00F0, "R2 last block addr", last_a, 32'h3000_00F0);
    end
    req_ready_i = 1'b0;
    #1;
    chk(!req_valid_o, "R10 no request when empty", req_valid_o, 0);
    exp_id = 4'h1;
    put_cmd(32'h3000_1000, 1, 16'h0, 4'h1, 1'b0);
    #1;
    chk(cmd_ready_o, "R8 admitted after drain", cmd_ready_o, 1);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    req_ready_i = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(push_bad == 0, "R9 strobe tag all", push_bad, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule